// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This peripheral keeps a free-running 32-bit up-count of timebase periods. A 16-bit down-counting prescaler divides the slow clock that drives the block. Each time the prescaler finishes a period, the count advances by one. If the prescaler value is set to the slow clock frequency in hertz, the count advances once per second. Software cannot load the count. The only way to change it is a restart, which sets the count back to zero and reloads the prescaler.

A 32-bit compare value raises an alarm flag on the advance that makes the count equal to it. The reset value of the compare is all ones, which software uses to mean that no alarm is set. A second flag latches on every advance. Both flags stay set until a read of the status word, which clears them. Each flag has its own enable, and the enabled flags are ORed onto a single interrupt line.

Software reaches the block through a single-cycle 32-bit register bus with four word registers:

| Byte offset | Register | Access | Fields |
|---|---|---|---|
| 0x0 | Control | read/write | bits 15:0 prescaler value; bit 16 alarm interrupt enable; bit 17 advance interrupt enable; bit 18 restart (write only) |
| 0x4 | Compare | read/write | 32-bit compare value |
| 0x8 | Count | read only | current 32-bit count |
| 0xC | Status | read, clears on read | bit 0 alarm flag; bit 1 advance flag |

Read data is combinational in the cycle that `rd_en` is high. Writes take effect at the clock edge that ends the access.

Top module: `rtt_timer`

## Requirements
- R1: After reset, the registers read as follows: control reads 0x00008000, compare reads 0xFFFFFFFF, count reads 0 and status reads 0. The `irq` output is 0.
- R2: Control bits 17:0 read back as they were written. Bit 18 (restart) and bits 31:19 always read 0. The compare register reads back the full 32-bit value written to it.
- R3: With prescaler value N from 1 to 65535, the count advances once every N clocks. Exactly k clocks after a restart edge, the count reads floor(k/N). A prescaler value of 0 divides by 65536.
- R4: Writing control with bit 18 set makes the count 0 at that edge. The prescaler restarts from the prescaler value written in the same access, and that access also updates the other control fields.
- R5: Writes to byte offsets 0x8 and 0xC have no effect. An access whose byte address is not word aligned (address bits 1:0 not 00) is ignored and reads as 0.
- R6: Status bit 1 is set at every clock edge where the count advances.
- R7: Status bit 0 is set at the advance that makes the count equal the compare value.
- R8: A status read returns the flags and clears them at the end of the read cycle. A flag event at that same edge leaves its flag set.
- R9: `irq` is high exactly while (status bit 0 AND control bit 16) OR (status bit 1 AND control bit 17) is true.
- R10: Writing a new prescaler value without restart does not disturb the current prescaler period. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler state shows as a count value that is off at the next period boundary. The count is sampled at exact clock offsets from a restart, so a single-cycle slip in the divide or in the reload is visible within one period. A flag that is lost or cleared at the wrong edge shows in the next status read or on `irq` in the same cycle. The test sets up reads that fall on an advance edge so that a dropped concurrent event is seen one read later. The 65536 divide is checked at its two edge cycles.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CMP    = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int unsigned FLAG_ALM = 0;
  localparam int unsigned FLAG_ADV = 1;
  localparam int unsigned N_FLAGS  = 2;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int unsigned PRE_W = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] restart_val,
  input  logic [PRE_W-1:0] reload_val,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  // Value 0 wraps down through all ones, giving a 2**PRE_W divide.
  assign tick = (pcnt_q == ONE);

  always_comb begin
    if (restart)   pcnt_d = restart_val;
    else if (tick) pcnt_d = reload_val;
    else           pcnt_d = pcnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= PRE_RST;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             adv_evt,
  output logic             alm_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             adv_en;

  assign adv_en  = tick && !restart;
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign adv_evt = adv_en;
  assign alm_evt = adv_en && (cnt_inc == cmp_val);
  assign count   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (adv_en) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtt_status.sv
module rtt_status #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt,
  input  logic [NF-1:0] en,
  input  logic          clr,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] flg_q, flg_d;

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_flag
      always_comb begin
        flg_d[g] = flg_q[g];
        if (clr)    flg_d[g] = 1'b0;
        if (evt[g]) flg_d[g] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
  assign irq   = |(flg_q & en);
endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned CNT_W = 32,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [N_FLAGS-1:0] flags,
  output logic [BUS_W-1:0]  rdata,
  output logic [PRE_W-1:0]  pre_val,
  output logic [PRE_W-1:0]  pre_nxt,
  output logic [N_FLAGS-1:0] irq_en,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              restart,
  output logic              st_clr
);
  localparam int unsigned EN_LO  = PRE_W;
  localparam int unsigned RST_B  = PRE_W + N_FLAGS;
  localparam int unsigned CTRL_W = PRE_W + N_FLAGS;

  logic              aligned;
  reg_sel_e          sel;
  logic              wr_ctrl, wr_cmp;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic              unused_wbits;

  assign aligned = (addr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr[3:2]);
  assign wr_ctrl = wr_en && aligned && (sel == SEL_CTRL);
  assign wr_cmp  = wr_en && aligned && (sel == SEL_CMP);

  assign ctrl_d  = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;
  assign cmp_d   = wr_cmp  ? wdata[CNT_W-1:0]  : cmp_q;
  assign restart = wr_ctrl && wdata[RST_B];
  assign st_clr  = rd_en && aligned && (sel == SEL_STATUS);
  assign unused_wbits = ^wdata[BUS_W-1:RST_B+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= {{N_FLAGS{1'b0}}, PRE_RST};
      cmp_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  assign pre_val = ctrl_q[PRE_W-1:0];
  assign pre_nxt = ctrl_d[PRE_W-1:0];
  assign irq_en  = ctrl_q[EN_LO +: N_FLAGS];
  assign cmp_val = cmp_q;

  always_comb begin
    rdata = '0;
    if (rd_en && aligned) begin
      unique case (sel)
        SEL_CTRL:   rdata[CTRL_W-1:0]  = ctrl_q;
        SEL_CMP:    rdata[CNT_W-1:0]   = cmp_q;
        SEL_COUNT:  rdata[CNT_W-1:0]   = count;
        SEL_STATUS: rdata[N_FLAGS-1:0] = flags;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned CNT_W = 32,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [PRE_W-1:0]   pre_val, pre_nxt;
  logic [N_FLAGS-1:0] irq_en, flags, evt;
  logic [CNT_W-1:0]   cmp_val, count;
  logic               restart, st_clr, tick, adv_evt, alm_evt;

  rtt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .PRE_RST(PRE_RST)) regs_i (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .flags(flags), .rdata(rdata),
    .pre_val(pre_val), .pre_nxt(pre_nxt), .irq_en(irq_en),
    .cmp_val(cmp_val), .restart(restart), .st_clr(st_clr)
  );

  rtt_prescaler #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) pre_i (
    .clk(clk), .rst_n(rst_q), .restart(restart), .restart_val(pre_nxt),
    .reload_val(pre_val), .tick(tick)
  );

  rtt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_q), .restart(restart), .tick(tick),
    .cmp_val(cmp_val), .count(count), .adv_evt(adv_evt), .alm_evt(alm_evt)
  );

  always_comb begin
    evt           = '0;
    evt[FLAG_ALM] = alm_evt;
    evt[FLAG_ADV] = adv_evt;
  end

  rtt_status #(.NF(N_FLAGS)) st_i (
    .clk(clk), .rst_n(rst_q), .evt(evt), .en(irq_en), .clr(st_clr),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/rtt_timer_chk.sv
module rtt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic             rd_en,
  input logic [3:0]       addr,
  input logic [31:0]      rdata,
  input logic             irq,
  input logic             restart,
  input logic             tick,
  input logic             st_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_val,
  input logic [1:0]       flags
);
  // R2
  restart_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && addr == 4'h0) |-> !rdata[18]);
  // R4
  restart_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_q)
    restart |=> (count == '0));
  // R3
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!tick && !restart) |=> $stable(count));
  // R6
  adv_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && !restart) |=> flags[1]);
  // R7
  alarm_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && !restart && (count + 1'b1 == cmp_val)) |=> flags[0]);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!st_clr && flags[0]) |=> flags[0]);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (flags == 2'b00) |-> !irq);
endmodule

bind rtt_timer rtt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_q(rst_q), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .restart(restart), .tick(tick), .st_clr(st_clr),
  .count(count), .cmp_val(cmp_val), .flags(flags)
);

// File: tb/rtt_timer_tb_top.sv
module rtt_timer_tb_top;
  logic        clk, rst_n, wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  rtt_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write, addr, data, expected}
  localparam logic [68:0] VEC [0:9] = '{
    {1'b0, 4'h0, 32'h0, 32'h0000_8000},
    {1'b0, 4'h4, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 4'h8, 32'h0, 32'h0000_0000},
    {1'b0, 4'hC, 32'h0, 32'h0000_0000},
    {1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'h0, 32'h0, 32'h0003_FFFF},
    {1'b1, 4'h4, 32'hA5A5_0F0F, 32'h0},
    {1'b0, 4'h4, 32'h0, 32'hA5A5_0F0F},
    {1'b1, 4'h0, 32'h0000_1234, 32'h0},
    {1'b0, 4'h0, 32'h0, 32'h0000_1234}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  task automatic restart_read(input logic [15:0] n, input int m, input logic [31:0] exp);
    wr(4'h0, {13'h0, 1'b1, 2'b00, n});
    idle(m);
    rd(4'h8, rv);
    chk("R3 count after restart", rv, exp);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk("R1 irq at reset", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][67:64], rv);
        chk(i < 4 ? "R1 reset value" : "R2 readback", rv, VEC[i][31:0]);
      end
    end

    // R5: ignored writes and unaligned access
    wr(4'h0, 32'h0004_0000);
    rd(4'hC, rv);
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, rv);  chk("R5 count write ignored", rv, 32'h0);
    wr(4'hC, 32'h3);
    rd(4'hC, rv);  chk("R5 status write ignored", rv, 32'h0);
    wr(4'h5, 32'h0);
    rd(4'h4, rv);  chk("R5 unaligned write ignored", rv, 32'hA5A5_0F0F);
    rd(4'h6, rv);  chk("R5 unaligned read zero", rv, 32'h0);

    // R3: divide ratios
    restart_read(16'd4, 3, 32'd0);
    restart_read(16'd4, 4, 32'd1);
    restart_read(16'd4, 9, 32'd2);
    restart_read(16'd1, 5, 32'd5);
    restart_read(16'd0, 65535, 32'd0);
    rd(4'h8, rv);  chk("R3 divide by 65536", rv, 32'd1);

    // R4: restart while running uses the new value
    wr(4'h0, 32'h0004_0002);
    idle(7);
    rd(4'h8, rv);  chk("R4 running count", rv, 32'd3);
    wr(4'h0, 32'h0004_0003);
    rd(4'h8, rv);  chk("R4 count zero after restart", rv, 32'd0);
    idle(1);
    rd(4'h8, rv);  chk("R4 new period pending", rv, 32'd0);
    rd(4'h8, rv);  chk("R4 new period applied", rv, 32'd1);

    // R10: reload change without restart
    wr(4'h0, 32'h0004_0003);
    idle(1);
    wr(4'h0, 32'h0000_0005);
    idle(1);
    rd(4'h8, rv);  chk("R10 old period finishes", rv, 32'd1);
    idle(3);
    rd(4'h8, rv);  chk("R10 new period running", rv, 32'd1);
    rd(4'h8, rv);  chk("R10 new period ends", rv, 32'd2);

    // R6 R8: read on an advance edge keeps that flag
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h0004_0004);
    idle(3);
    rd(4'hC, rv);
    rd(4'hC, rv);  chk("R6 R8 flag kept on concurrent read", rv, 32'h2);
    rd(4'hC, rv);  chk("R8 flags cleared by read", rv, 32'h0);

    // R7: alarm at count 3, alarm interrupt only
    wr(4'h4, 32'd3);
    rd(4'hC, rv);
    wr(4'h0, 32'h0005_0002);
    idle(5);
    chk("R7 no irq before match", {31'h0, irq}, 32'h0);
    idle(1);
    chk("R7 irq on match", {31'h0, irq}, 32'h1);
    rd(4'hC, rv);  chk("R7 alarm flag", rv, 32'h3);
    chk("R8 irq drops after read", {31'h0, irq}, 32'h0);

    // R9: enable gating
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h0005_0002);
    idle(3);
    chk("R9 advance flag masked", {31'h0, irq}, 32'h0);
    wr(4'h0, 32'h0003_0002);
    chk("R9 advance flag enabled", {31'h0, irq}, 32'h1);
    rd(4'hC, rv);  chk("R9 status seen", rv, 32'h2);
    chk("R9 irq low after clear", {31'h0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule